// File: doc/BRIEF.md
# Packed Palette Lookup RAM

This block is a grey/colour lookup table with 256 logical entries, each 16 bits wide. The entries are kept two to a word in a 128-deep, 32-bit memory. Software-side logic loads and inspects the table one 32-bit word at a time, through a write port and a readback port that both take a word address. A display pipeline presents pixel indices on a separate lookup port and gets the matching 16-bit entry back one clock later.

The pixel depth is programmable. At depths below 8 bits per pixel, only the low index bits take part in the lookup. The upper index bits are forced to zero, so a shallow image always uses the first 2, 4 or 16 entries of the table.

Top module: `packed_palette`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it has been sampled low, `px_entry_valid` is 0, `px_entry` is 0 and `rd_data` is 0.
- R2: A word written with `wr_en` high at `wr_addr` is returned on `rd_data` one clock after `rd_addr` selects it.
- R3: `px_entry_valid` equals `px_valid` delayed by exactly one clock.
- R4: In 8 bpp mode (`bpp_mode` = 3), index bits 7:1 select the word, and an even index returns bits 15:0 of that word.
- R5: An odd index returns bits 31:16 of the selected word.
- R6: `bpp_mode` codes are 0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp and 3 = 8 bpp. At depths below 8, the index is zero-extended from its low 1, 2 or 4 bits, and its higher bits have no effect.
- R7: If a write and a lookup address the same word in the same cycle, the lookup returns the contents from before the write. The written value is visible from the next cycle on.
- R8: When `px_entry_valid` is 0, `px_entry` is 0.
- R9: Reset leaves the memory contents unchanged.
- R10: While `wr_en` is low, `wr_addr` and `wr_data` have no effect on the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the output registers |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | 7 | Word address for writes |
| wr_data | input | 32 | Word to write: odd entry in 31:16, even entry in 15:0 |
| rd_addr | input | 7 | Word address for readback |
| rd_data | output | 32 | Readback word, one clock after `rd_addr` |
| px_valid | input | 1 | Lookup request |
| px_index | input | 8 | Pixel index |
| bpp_mode | input | 2 | Pixel depth code |
| px_entry | output | 16 | Looked-up entry |
| px_entry_valid | output | 1 | Entry valid, one clock after `px_valid` |

## Verification
The bench fills every word with entries that differ from one another, so a wrong halfword choice returns a visibly wrong value. So does a swapped word address or a missing index mask at 1, 2 or 4 bpp. It drives a write and a lookup to the same word in the same cycle: a design that forwards the new data would return the new entry at once instead of the old one. It pulses reset after loading the table and reads a word back, which catches a memory that gets cleared. It counts the exact cycle of the valid flag, so a design with two stages or none is caught on timing.

// File: rtl/pal_pkg.sv
// Shared definitions for the packed palette: the pixel depth codes.
package pal_pkg;
    typedef enum logic [1:0] {
        BPP_1 = 2'd0,
        BPP_2 = 2'd1,
        BPP_4 = 2'd2,
        BPP_8 = 2'd3
    } bpp_e;
endpackage

// File: rtl/pal_index_mask.sv
// Index masking: keeps only the index bits that the pixel depth makes
// meaningful and zero-extends the rest. This logic is purely combinational.
// Assumes INDEX_W >= 4.
module pal_index_mask #(
    parameter int INDEX_W = 8
) (
    input  pal_pkg::bpp_e        mode,
    input  logic [INDEX_W-1:0]   raw_index,
    output logic [INDEX_W-1:0]   eff_index
);
    logic [INDEX_W-1:0] keep;

    // Build the keep mask for the selected depth.
    always_comb begin
        case (mode)
            pal_pkg::BPP_1: keep = INDEX_W'(1);
            pal_pkg::BPP_2: keep = INDEX_W'(3);
            pal_pkg::BPP_4: keep = INDEX_W'(15);
            default:        keep = '1;
        endcase
    end

    assign eff_index = raw_index & keep;
endmodule

// File: rtl/pal_word_store.sv
// Word storage: DEPTH words of WORD_W bits, with one write port and two
// registered read ports (readback and lookup). A read of a word that is
// being written in the same cycle returns the old contents. The array has
// no reset; only the read registers are cleared.
module pal_word_store #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 128,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              lk_en,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic [WORD_W-1:0] lk_word
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Store a word on each write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Readback register: follows rd_addr every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= mem[rd_addr];
        end
    end

    // Lookup register: loads the addressed word when a lookup is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_word <= '0;
        end else if (lk_en) begin
            lk_word <= mem[lk_addr];
        end
    end
endmodule

// File: rtl/pal_half_select.sv
// Halfword select: tracks the valid flag and the index LSB alongside the
// registered lookup word, and picks the low half (even entry) or the high
// half (odd entry). The output is zero while no entry is valid.
module pal_half_select #(
    parameter int ENTRY_W = 16,
    localparam int WORD_W = 2 * ENTRY_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_en,
    input  logic               lk_half,
    input  logic [WORD_W-1:0]  word_q,
    output logic [ENTRY_W-1:0] entry,
    output logic               entry_valid
);
    logic half_q;
    logic valid_q;
    logic [ENTRY_W-1:0] lanes [2];

    // Delay the valid flag and halfword select to line up with the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            half_q  <= 1'b0;
        end else begin
            valid_q <= lk_en;
            if (lk_en) begin
                half_q <= lk_half;
            end
        end
    end

    // Split the word into its two entry lanes, low lane first.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign lanes[g] = word_q[g*ENTRY_W +: ENTRY_W];
    end

    // Select the lane, or force zero when no entry is valid.
    always_comb begin
        entry = valid_q ? lanes[half_q] : '0;
    end

    assign entry_valid = valid_q;
endmodule

// File: rtl/packed_palette.sv
// Packed palette top: 2**INDEX_W entries of ENTRY_W bits, stored two per
// word. Index bits above bit 0 select the word and bit 0 selects the half.
// Lookups have a latency of one clock. Reset clears the output registers
// but not the table contents.
module packed_palette #(
    parameter int ENTRY_W = 16,
    parameter int INDEX_W = 8,
    localparam int WORD_W = 2 * ENTRY_W,
    localparam int ADDR_W = INDEX_W - 1,
    localparam int DEPTH  = 2 ** ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [WORD_W-1:0]  rd_data,
    input  logic               px_valid,
    input  logic [INDEX_W-1:0] px_index,
    input  logic [1:0]         bpp_mode,
    output logic [ENTRY_W-1:0] px_entry,
    output logic               px_entry_valid
);
    logic [INDEX_W-1:0] eff_index;
    logic [ADDR_W-1:0]  lk_word_addr;
    logic [WORD_W-1:0]  lk_word;

    pal_index_mask #(.INDEX_W(INDEX_W)) u_mask (
        .mode      (pal_pkg::bpp_e'(bpp_mode)),
        .raw_index (px_index),
        .eff_index (eff_index)
    );

    assign lk_word_addr = eff_index[INDEX_W-1:1];

    pal_word_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .lk_en   (px_valid),
        .lk_addr (lk_word_addr),
        .lk_word (lk_word)
    );

    pal_half_select #(.ENTRY_W(ENTRY_W)) u_half (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_en       (px_valid),
        .lk_half     (eff_index[0]),
        .word_q      (lk_word),
        .entry       (px_entry),
        .entry_valid (px_entry_valid)
    );
endmodule

// File: rtl/packed_palette_checker.sv
// Property checker for packed_palette, attached through bind. It observes
// the ports and the word address that the mask stage passes to storage.
module packed_palette_checker #(
    parameter int ENTRY_W = 16,
    parameter int INDEX_W = 8,
    localparam int WORD_W = 2 * ENTRY_W,
    localparam int ADDR_W = INDEX_W - 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               px_valid,
    input logic [1:0]         bpp_mode,
    input logic [ADDR_W-1:0]  lk_addr,
    input logic [ENTRY_W-1:0] px_entry,
    input logic               px_entry_valid,
    input logic [WORD_W-1:0]  rd_data
);
    logic saw_reset = 1'b0;

    // Remember whether reset was sampled low at the last edge.
    always @(posedge clk) saw_reset <= !rst_n;

    // Outputs are cleared after a sampled reset (R1).
    always @(negedge clk) begin
        if (saw_reset) begin
            assert_reset_clear_R1: assert (!px_entry_valid && px_entry == '0 && rd_data == '0)
                else $error("outputs not cleared by reset");
        end
    end

    assert_valid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |=> px_entry_valid);

    assert_idle_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !px_valid |=> !px_entry_valid);

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !px_entry_valid |-> px_entry == '0);

    assert_mask_1bpp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid && bpp_mode == 2'd0) |-> lk_addr == '0);

    assert_mask_2bpp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid && bpp_mode == 2'd1) |-> lk_addr[ADDR_W-1:1] == '0);
endmodule

bind packed_palette packed_palette_checker #(.ENTRY_W(ENTRY_W), .INDEX_W(INDEX_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .px_valid       (px_valid),
    .bpp_mode       (bpp_mode),
    .lk_addr        (lk_word_addr),
    .px_entry       (px_entry),
    .px_entry_valid (px_entry_valid),
    .rd_data        (rd_data)
);

// File: tb/packed_palette_test.sv
// Directed bench for packed_palette: one task per scenario.
module packed_palette_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [6:0]  wr_addr;
    logic [31:0] wr_data;
    logic [6:0]  rd_addr;
    logic [31:0] rd_data;
    logic        px_valid;
    logic [7:0]  px_index;
    logic [1:0]  bpp_mode;
    logic [15:0] px_entry;
    logic        px_entry_valid;

    logic [31:0] ref_mem [128];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    packed_palette uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .px_valid(px_valid), .px_index(px_index), .bpp_mode(bpp_mode),
        .px_entry(px_entry), .px_entry_valid(px_entry_valid)
    );

    function automatic logic [15:0] ent(input int e);
        return {8'(e) ^ 8'h5A, 8'(e)};
    endfunction

    function automatic logic [15:0] ref_ent(input logic [7:0] idx);
        return idx[0] ? ref_mem[idx[7:1]][31:16] : ref_mem[idx[7:1]][15:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        ref_mem[a] = d;
    endtask

    task automatic readback(input logic [6:0] a, input string req);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
        chk(rd_data == ref_mem[a], req, rd_data, ref_mem[a]);
    endtask

    task automatic lookup(input logic [7:0] idx, input logic [1:0] mode, input logic [15:0] exp, input string req);
        @(negedge clk);
        px_valid = 1'b1; px_index = idx; bpp_mode = mode;
        @(negedge clk);
        px_valid = 1'b0;
        chk(px_entry_valid && px_entry == exp, req, {15'd0, px_entry_valid, px_entry}, {16'h0001, exp});
    endtask

    // R1: reset state of the outputs.
    task automatic t_reset;
        chk(px_entry_valid == 1'b0, "R1 valid", 32'(px_entry_valid), 0);
        chk(px_entry == '0, "R1 entry", 32'(px_entry), 0);
        chk(rd_data == '0, "R1 rd_data", rd_data, 0);
    endtask

    // R2: load the whole table and read some words back.
    task automatic t_fill_readback;
        for (int w = 0; w < 128; w++) write_word(7'(w), {ent(2*w+1), ent(2*w)});
        readback(7'd0, "R2 word0");
        readback(7'd77, "R2 word77");
        readback(7'd127, "R2 word127");
    endtask

    // R4/R5: full-depth lookups of even and odd entries.
    task automatic t_lookup_8bpp;
        lookup(8'h00, 2'd3, ent(0), "R4 idx00");
        lookup(8'h7E, 2'd3, ent(8'h7E), "R4 idx7E");
        lookup(8'h01, 2'd3, ent(1), "R5 idx01");
        lookup(8'hFF, 2'd3, ent(8'hFF), "R5 idxFF");
        lookup(8'h81, 2'd3, ent(8'h81), "R5 idx81");
    endtask

    // R3/R8: exact cycle of the valid flag; zero entry when idle.
    task automatic t_latency;
        @(negedge clk);
        px_valid = 1'b1; px_index = 8'h10; bpp_mode = 2'd3;
        chk(px_entry_valid == 1'b0, "R3 not early", 32'(px_entry_valid), 0);
        @(negedge clk);
        px_valid = 1'b0;
        chk(px_entry_valid == 1'b1, "R3 one cycle", 32'(px_entry_valid), 1);
        chk(px_entry == ent(8'h10), "R3 data", 32'(px_entry), 32'(ent(8'h10)));
        @(negedge clk);
        chk(px_entry_valid == 1'b0, "R3 drop", 32'(px_entry_valid), 0);
        chk(px_entry == '0, "R8 idle zero", 32'(px_entry), 0);
    endtask

    // R6: depth masking of the index.
    task automatic t_bpp_mask;
        lookup(8'hFF, 2'd0, ent(1), "R6 1bpp");
        lookup(8'hFE, 2'd0, ent(0), "R6 1bpp even");
        lookup(8'hFE, 2'd1, ent(2), "R6 2bpp");
        lookup(8'hA7, 2'd2, ent(7), "R6 4bpp");
        lookup(8'hA7, 2'd3, ent(8'hA7), "R6 8bpp");
    endtask

    // R7: same-cycle write and lookup of one word.
    task automatic t_collision;
        logic [31:0] nw;
        nw = 32'hBEEF_CAFE;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'd3; wr_data = nw;
        px_valid = 1'b1; px_index = 8'h07; bpp_mode = 2'd3;
        @(negedge clk);
        wr_en = 1'b0; px_valid = 1'b0;
        chk(px_entry == ent(7), "R7 old data", 32'(px_entry), 32'(ent(7)));
        ref_mem[3] = nw;
        lookup(8'h07, 2'd3, nw[31:16], "R7 new data");
        lookup(8'h06, 2'd3, nw[15:0], "R7 new low");
    endtask

    // R10: the write bus has no effect without the strobe.
    task automatic t_no_write;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 7'd9; wr_data = 32'h1234_5678;
        @(negedge clk);
        readback(7'd9, "R10 unchanged");
        lookup(8'h12, 2'd3, ref_ent(8'h12), "R10 lookup unchanged");
    endtask

    // R9/R1: reset mid-run keeps the table.
    task automatic t_reset_keep;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(rd_data == '0 && !px_entry_valid, "R1 re-reset", rd_data, 0);
        rst_n = 1'b1;
        readback(7'd5, "R9 kept word5");
        lookup(8'h0B, 2'd3, ref_ent(8'h0B), "R9 kept entry");
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = '0; px_valid = 1'b0; px_index = '0; bpp_mode = 2'd3;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_fill_readback();
        t_lookup_8bpp();
        t_latency();
        t_bpp_mask();
        t_collision();
        t_no_write();
        t_reset_keep();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule